// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This unit follows one vectorised load or store while it issues its element accesses in order. Each element reports its index, its effective address and whether address translation or permission checks would fault. The unit decides, for each element, whether the fault becomes a trap, whether the rest of the sequence is dropped, and what the final vector length is.

In fail-first mode, element 0 behaves like an ordinary scalar access: a fault on it traps and the length is left as requested. A fault on any later element never traps. That access is cancelled instead and the vector length is cut to that element's index. The unit can also cut the length early for its own reasons: an explicit truncation request, an alignment boundary in the address stream, or a minimal configuration that always keeps one element. It never cuts the length to zero. Requests that may not run in fail-first mode are handled when the sequence starts. A vertical-first request is refused. A request with a vector-indexed base is either refused or demoted to element-strided, as chosen by a parameter.

A sequence opens with a one-cycle `start` pulse that carries the request. The element beats follow from the next cycle on. Every result is registered and appears in the cycle after the beat that caused it.

Top module: `ffvl_unit`

## Requirements
- R1: After reset, `raise_exc`, `cancel`, `done`, `unsupported` and `strided` are 0 and `vl_out` is 0.
- R2: In fail-first mode, a fault on element 0 gives `raise_exc` and `done` together, with `vl_out` equal to the requested length.
- R3: In fail-first mode, a fault on an element with index 1 or above gives `cancel` and `done` but never `raise_exc`, and sets `vl_out` to that index. Any beats after that produce no further `done`.
- R4: When no element cuts the sequence, `done` follows the beat at index length−1, and `vl_out` is the effective length.
- R5: With fail-first off, a fault on any element gives `raise_exc` and `done` with `vl_out` unchanged. Truncation and alignment requests have no effect.
- R6: A fail-first request with an indexed base behaves according to `REFUSE_INDEXED`. With 0, the request runs and `strided` is 1 until the next start. With 1, the start cycle gives `unsupported` and `done` with `vl_out` equal to the request.
- R7: A fail-first request in vertical-first mode gives `unsupported` and `done` in the start cycle, with `vl_out` equal to the request.
- R8: With `min_mode` set on a fail-first request of length 1 or more, the effective length is 1. Without a fault, `done` follows element 0 with `vl_out` = 1.
- R9: In fail-first mode, `trunc_req` on an element with index 1 or above cancels it and sets `vl_out` to its index. On element 0 it has no effect.
- R10: In fail-first mode with `align_en` set, the first element with index 1 or above whose address has its low `align_log2` bits all zero is cancelled, and `vl_out` becomes its index. An `align_log2` of 0 disables this.
- R11: A request of length 0 that is not refused gives `done` in the start cycle with `vl_out` = 0 and no `cancel`.
- R12: `cancel` is never asserted together with `vl_out` = 0, and `cancel` and `raise_exc` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a sequence and samples the request fields |
| req_vl | input | VLW | Requested vector length |
| ff_en | input | 1 | Fail-first mode requested |
| indexed | input | 1 | Base is a vector of addresses |
| vert_first | input | 1 | Request issued in vertical-first mode |
| min_mode | input | 1 | Minimal configuration: keep only one element |
| align_en | input | 1 | Enable alignment-boundary truncation |
| align_log2 | input | ALW | Boundary size as a power of two |
| elem_valid | input | 1 | Element beat present |
| elem_idx | input | IDXW | Element index of the beat |
| elem_addr | input | AW | Effective address of the element |
| elem_fault | input | 1 | Access would raise an exception |
| trunc_req | input | 1 | Implementation-chosen cut at this element |
| raise_exc | output | 1 | Take the exception (one-cycle pulse) |
| cancel | output | 1 | This and later elements are dropped (pulse) |
| done | output | 1 | Sequence finished (pulse) |
| vl_out | output | VLW | Final vector length, held until the next result |
| unsupported | output | 1 | Request refused (pulse) |
| strided | output | 1 | Indexed request demoted to element-strided |

## Verification
The bench builds the unit with `VL_MAX` = 8 and an 8-bit address, so every requested length from 0 to 8 can be combined with every fault position, and with no fault, in both fail-first settings. It also covers every truncation position and every boundary size from 0 to 3 over all base offsets and three strides. Two instances run side by side, one for each indexed-base policy, so both treatments of an indexed request are checked against the same stimulus. Each run feeds all eight beats, so beats that arrive after the end of a sequence are checked as well.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

  // How a single element beat closes (or does not close) the sequence
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_RAISE = 2'd1,
    END_CUT   = 2'd2,
    END_FULL  = 2'd3
  } ffvl_end_e;

endpackage

// File: rtl/ffvl_mode_decode.sv
module ffvl_mode_decode #(
  parameter int VLW            = 7,
  parameter bit REFUSE_INDEXED = 1'b0
) (
  input  logic           ff_en,
  input  logic           indexed,
  input  logic           vert_first,
  input  logic           min_mode,
  input  logic [VLW-1:0] req_vl,
  output logic           refuse,
  output logic           strided,
  output logic           ff_act,
  output logic [VLW-1:0] lim
);

  generate
    if (REFUSE_INDEXED) begin : g_refuse_idx
      assign refuse  = ff_en && (vert_first || indexed);
      assign strided = 1'b0;
    end else begin : g_demote_idx
      assign refuse  = ff_en && vert_first;
      assign strided = ff_en && !vert_first && indexed;
    end
  endgenerate

  assign ff_act = ff_en && !refuse;

  always_comb begin
    if (ff_act && min_mode && (req_vl != '0)) lim = VLW'(1);
    else                                      lim = req_vl;
  end

endmodule

// File: rtl/ffvl_align_detect.sv
module ffvl_align_detect #(
  parameter int AW  = 64,
  parameter int ALW = 7
) (
  input  logic           align_en,
  input  logic [ALW-1:0] align_log2,
  input  logic [AW-1:0]  addr,
  output logic           hit
);

  logic [AW-1:0] mask;

  always_comb begin
    mask = (AW'(1) << align_log2) - AW'(1);
    hit  = align_en && (align_log2 != '0) && ((addr & mask) == '0);
  end

endmodule

// File: rtl/ffvl_seq.sv
module ffvl_seq
  import ffvl_pkg::*;
#(
  parameter int VLW  = 7,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VLW-1:0]  req_vl,
  input  logic            refuse,
  input  logic            strided_d,
  input  logic            ff_act,
  input  logic [VLW-1:0]  lim,
  input  logic            elem_valid,
  input  logic [IDXW-1:0] elem_idx,
  input  logic            elem_fault,
  input  logic            trunc_req,
  input  logic            align_hit,
  output logic            raise_exc,
  output logic            cancel,
  output logic            done,
  output logic [VLW-1:0]  vl_out,
  output logic            unsupported,
  output logic            strided,
  output logic            ff_q
);

  logic           active;
  logic [VLW-1:0] lim_q;
  logic [VLW-1:0] req_q;
  logic [VLW-1:0] idx_w;
  logic           in_range;
  logic           late;
  ffvl_end_e      ending;

  assign idx_w    = VLW'(elem_idx);
  assign in_range = active && elem_valid && (idx_w < lim_q);
  assign late     = (elem_idx != '0);

  always_comb begin
    ending = END_NONE;
    if (in_range) begin
      if (elem_fault && (!late || !ff_q))
        ending = END_RAISE;
      else if (ff_q && late && (elem_fault || trunc_req || align_hit))
        ending = END_CUT;
      else if (idx_w == lim_q - VLW'(1))
        ending = END_FULL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      lim_q       <= '0;
      req_q       <= '0;
      ff_q        <= 1'b0;
      raise_exc   <= 1'b0;
      cancel      <= 1'b0;
      done        <= 1'b0;
      vl_out      <= '0;
      unsupported <= 1'b0;
      strided     <= 1'b0;
    end else begin
      raise_exc   <= 1'b0;
      cancel      <= 1'b0;
      done        <= 1'b0;
      unsupported <= 1'b0;
      if (start) begin
        ff_q    <= ff_act;
        lim_q   <= lim;
        req_q   <= req_vl;
        strided <= strided_d;
        if (refuse) begin
          unsupported <= 1'b1;
          done        <= 1'b1;
          vl_out      <= req_vl;
          active      <= 1'b0;
        end else if (lim == '0) begin
          done   <= 1'b1;
          vl_out <= '0;
          active <= 1'b0;
        end else begin
          active <= 1'b1;
        end
      end else begin
        case (ending)
          END_RAISE: begin
            raise_exc <= 1'b1;
            done      <= 1'b1;
            vl_out    <= req_q;
            active    <= 1'b0;
          end
          END_CUT: begin
            cancel <= 1'b1;
            done   <= 1'b1;
            vl_out <= idx_w;
            active <= 1'b0;
          end
          END_FULL: begin
            done   <= 1'b1;
            vl_out <= lim_q;
            active <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ffvl_unit.sv
module ffvl_unit #(
  parameter int  VL_MAX         = 64,
  parameter int  AW             = 64,
  parameter bit  REFUSE_INDEXED = 1'b0,
  localparam int VLW            = $clog2(VL_MAX + 1),
  localparam int IDXW           = $clog2(VL_MAX),
  localparam int ALW            = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VLW-1:0]  req_vl,
  input  logic            ff_en,
  input  logic            indexed,
  input  logic            vert_first,
  input  logic            min_mode,
  input  logic            align_en,
  input  logic [ALW-1:0]  align_log2,
  input  logic            elem_valid,
  input  logic [IDXW-1:0] elem_idx,
  input  logic [AW-1:0]   elem_addr,
  input  logic            elem_fault,
  input  logic            trunc_req,
  output logic            raise_exc,
  output logic            cancel,
  output logic            done,
  output logic [VLW-1:0]  vl_out,
  output logic            unsupported,
  output logic            strided
);

  logic           refuse;
  logic           strided_d;
  logic           ff_act;
  logic [VLW-1:0] lim;
  logic           align_hit;
  logic           ff_q;

  ffvl_mode_decode #(.VLW(VLW), .REFUSE_INDEXED(REFUSE_INDEXED)) u_dec (
    .ff_en      (ff_en),
    .indexed    (indexed),
    .vert_first (vert_first),
    .min_mode   (min_mode),
    .req_vl     (req_vl),
    .refuse     (refuse),
    .strided    (strided_d),
    .ff_act     (ff_act),
    .lim        (lim)
  );

  ffvl_align_detect #(.AW(AW), .ALW(ALW)) u_aln (
    .align_en   (align_en),
    .align_log2 (align_log2),
    .addr       (elem_addr),
    .hit        (align_hit)
  );

  ffvl_seq #(.VLW(VLW), .IDXW(IDXW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .req_vl      (req_vl),
    .refuse      (refuse),
    .strided_d   (strided_d),
    .ff_act      (ff_act),
    .lim         (lim),
    .elem_valid  (elem_valid),
    .elem_idx    (elem_idx),
    .elem_fault  (elem_fault),
    .trunc_req   (trunc_req),
    .align_hit   (align_hit),
    .raise_exc   (raise_exc),
    .cancel      (cancel),
    .done        (done),
    .vl_out      (vl_out),
    .unsupported (unsupported),
    .strided     (strided),
    .ff_q        (ff_q)
  );

endmodule

// File: rtl/ffvl_checker.sv
module ffvl_checker #(
  parameter int VLW  = 7,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            raise_exc,
  input logic            cancel,
  input logic            done,
  input logic [VLW-1:0]  vl_out,
  input logic            unsupported,
  input logic [IDXW-1:0] elem_idx,
  input logic            ff_q
);

  assert_raise_ends_R2: assert property (@(posedge clk) disable iff (rst)
    raise_exc |-> done);

  assert_cut_ends_R3: assert property (@(posedge clk) disable iff (rst)
    cancel |-> (done && !raise_exc));

  assert_late_no_trap_R3: assert property (@(posedge clk) disable iff (rst)
    (raise_exc && ff_q) |-> ($past(elem_idx) == '0));

  assert_cut_at_index_R3: assert property (@(posedge clk) disable iff (rst)
    cancel |-> (vl_out == VLW'($past(elem_idx))));

  assert_never_zero_R12: assert property (@(posedge clk) disable iff (rst)
    cancel |-> (vl_out != '0));

  assert_refuse_clean_R7: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> (done && !cancel && !raise_exc));

endmodule

bind ffvl_unit ffvl_checker #(.VLW(VLW), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .raise_exc   (raise_exc),
  .cancel      (cancel),
  .done        (done),
  .vl_out      (vl_out),
  .unsupported (unsupported),
  .elem_idx    (elem_idx),
  .ff_q        (ff_q)
);

// File: tb/sim_ffvl_unit.sv
module sim_ffvl_unit;
  localparam int VL_MAX = 8;
  localparam int AW     = 8;
  localparam int VLW    = $clog2(VL_MAX + 1);
  localparam int IDXW   = $clog2(VL_MAX);
  localparam int ALW    = $clog2(AW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            start = 0, ff_en = 0, indexed = 0, vert_first = 0, min_mode = 0;
  logic            align_en = 0, elem_valid = 0, elem_fault = 0, trunc_req = 0;
  logic [VLW-1:0]  req_vl = '0;
  logic [ALW-1:0]  align_log2 = '0;
  logic [IDXW-1:0] elem_idx = '0;
  logic [AW-1:0]   elem_addr = '0;

  logic            raise0, cancel0, done0, unsup0, str0;
  logic [VLW-1:0]  vl0;
  logic            raise1, cancel1, done1, unsup1, str1;
  logic [VLW-1:0]  vl1;

  ffvl_unit #(.VL_MAX(VL_MAX), .AW(AW), .REFUSE_INDEXED(1'b0)) u0 (
    .clk(clk), .rst(rst), .start(start), .req_vl(req_vl), .ff_en(ff_en),
    .indexed(indexed), .vert_first(vert_first), .min_mode(min_mode),
    .align_en(align_en), .align_log2(align_log2), .elem_valid(elem_valid),
    .elem_idx(elem_idx), .elem_addr(elem_addr), .elem_fault(elem_fault),
    .trunc_req(trunc_req), .raise_exc(raise0), .cancel(cancel0), .done(done0),
    .vl_out(vl0), .unsupported(unsup0), .strided(str0));

  ffvl_unit #(.VL_MAX(VL_MAX), .AW(AW), .REFUSE_INDEXED(1'b1)) u1 (
    .clk(clk), .rst(rst), .start(start), .req_vl(req_vl), .ff_en(ff_en),
    .indexed(indexed), .vert_first(vert_first), .min_mode(min_mode),
    .align_en(align_en), .align_log2(align_log2), .elem_valid(elem_valid),
    .elem_idx(elem_idx), .elem_addr(elem_addr), .elem_fault(elem_fault),
    .trunc_req(trunc_req), .raise_exc(raise1), .cancel(cancel1), .done(done1),
    .vl_out(vl1), .unsupported(unsup1), .strided(str1));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // stimulus of the current run
  int s_vl, s_ff, s_idx, s_vf, s_min, s_aen, s_alog, s_base, s_step, s_fault, s_trunc;

  // observations per instance
  int o_done[2], o_vl[2], o_raise[2], o_cancel[2], o_unsup[2];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (vl=%0d ff=%0d idx=%0d vf=%0d min=%0d aen=%0d alog=%0d base=%0d step=%0d fault=%0d trunc=%0d)",
               tag, what, act, exp, s_vl, s_ff, s_idx, s_vf, s_min, s_aen, s_alog,
               s_base, s_step, s_fault, s_trunc);
    end
  endtask

  function automatic int addr_of(input int i);
    return (s_base + i * s_step) % (1 << AW);
  endfunction

  task automatic model(input int refuse, output int e_vl, output int e_raise,
                       output int e_cancel, output int e_unsup, output int e_str,
                       output string tag);
    int ffa, refused, lim, hit;
    refused  = s_ff && (s_vf || (s_idx && refuse));
    ffa      = s_ff && !refused;
    e_str    = ffa && s_idx && !refuse;
    lim      = (ffa && s_min && s_vl > 0) ? 1 : s_vl;
    e_raise  = 0; e_cancel = 0; e_unsup = 0; e_vl = s_vl;
    tag      = "R4";
    if (refused) begin
      e_unsup = 1; tag = s_vf ? "R7" : "R6";
    end else if (lim == 0) begin
      e_vl = 0; tag = "R11";
    end else begin
      for (int i = 0; i < lim; i++) begin
        hit = s_aen && (s_alog != 0) && ((addr_of(i) % (1 << s_alog)) == 0);
        if (s_fault == i && (i == 0 || !ffa)) begin
          e_raise = 1; e_vl = s_vl; tag = ffa ? "R2" : "R5"; break;
        end
        if (ffa && i != 0 && (s_fault == i || s_trunc == i || hit)) begin
          e_cancel = 1; e_vl = i;
          tag = (s_fault == i) ? "R3" : ((s_trunc == i) ? "R9" : "R10");
          break;
        end
        if (i == lim - 1) begin
          e_vl = lim;
          tag = (ffa && s_min) ? "R8" : (s_ff ? "R4" : "R5");
        end
      end
    end
  endtask

  task automatic observe();
    if (done0) begin o_done[0]++; o_vl[0] = int'(vl0); end
    if (done1) begin o_done[1]++; o_vl[1] = int'(vl1); end
    o_raise[0]  |= int'(raise0);  o_raise[1]  |= int'(raise1);
    o_cancel[0] |= int'(cancel0); o_cancel[1] |= int'(cancel1);
    o_unsup[0]  |= int'(unsup0);  o_unsup[1]  |= int'(unsup1);
    if (cancel0 && vl0 == '0) chk("R12", "cut to zero u0", 1, 0);
    if (cancel1 && vl1 == '0) chk("R12", "cut to zero u1", 1, 0);
  endtask

  task automatic run();
    int e_vl, e_raise, e_cancel, e_unsup, e_str;
    string tag;
    for (int u = 0; u < 2; u++) begin
      o_done[u] = 0; o_vl[u] = -1; o_raise[u] = 0; o_cancel[u] = 0; o_unsup[u] = 0;
    end
    @(negedge clk);
    start = 1; req_vl = VLW'(s_vl); ff_en = s_ff[0]; indexed = s_idx[0];
    vert_first = s_vf[0]; min_mode = s_min[0]; align_en = s_aen[0];
    align_log2 = ALW'(s_alog); elem_valid = 0;
    @(negedge clk);
    start = 0;
    observe();
    for (int i = 0; i < VL_MAX; i++) begin
      elem_valid = 1; elem_idx = IDXW'(i); elem_addr = AW'(addr_of(i));
      elem_fault = (s_fault == i); trunc_req = (s_trunc == i);
      @(negedge clk);
      observe();
    end
    elem_valid = 0; elem_fault = 0; trunc_req = 0;
    @(negedge clk);
    observe();
    for (int u = 0; u < 2; u++) begin
      model(u, e_vl, e_raise, e_cancel, e_unsup, e_str, tag);
      chk(tag, $sformatf("done count u%0d", u), o_done[u], 1);
      chk(tag, $sformatf("vl_out u%0d", u), o_vl[u], e_vl);
      chk(tag, $sformatf("raise u%0d", u), o_raise[u], e_raise);
      chk(tag, $sformatf("cancel u%0d", u), o_cancel[u], e_cancel);
      chk(tag, $sformatf("unsupported u%0d", u), o_unsup[u], e_unsup);
      chk(e_str ? "R6" : tag, $sformatf("strided u%0d", u),
          (u == 0) ? int'(str0) : int'(str1), e_str);
    end
  endtask

  task automatic clear_stim();
    s_vl = 0; s_ff = 0; s_idx = 0; s_vf = 0; s_min = 0; s_aen = 0; s_alog = 0;
    s_base = 0; s_step = 1; s_fault = 99; s_trunc = 99;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "raise", int'(raise0), 0);
    chk("R1", "cancel", int'(cancel0), 0);
    chk("R1", "done", int'(done0), 0);
    chk("R1", "vl_out", int'(vl0), 0);
    chk("R1", "unsupported", int'(unsup0), 0);
    chk("R1", "strided", int'(str1), 0);

    // R2 R3 R4 R5 R11: every length, every fault position, both fail-first settings
    for (int vl = 0; vl <= VL_MAX; vl++)
      for (int ff = 0; ff < 2; ff++)
        for (int f = 0; f <= vl; f++) begin
          clear_stim(); s_vl = vl; s_ff = ff; s_fault = (f == vl) ? 99 : f;
          run();
        end

    // R9 with R5: implementation cut at every index, fail-first on and off
    for (int ff = 0; ff < 2; ff++)
      for (int t = 0; t < VL_MAX; t++) begin
        clear_stim(); s_vl = VL_MAX; s_ff = ff; s_trunc = t;
        run();
      end

    // R10 with R5: boundary sizes, base offsets and strides
    for (int ff = 0; ff < 2; ff++)
      for (int al = 0; al <= 3; al++)
        for (int b = 0; b < 8; b++)
          for (int st = 1; st <= 3; st++) begin
            clear_stim(); s_vl = VL_MAX; s_ff = ff; s_aen = 1; s_alog = al;
            s_base = b; s_step = st;
            run();
          end

    // R8: minimal configuration
    for (int vl = 0; vl <= VL_MAX; vl++)
      for (int ff = 0; ff < 2; ff++)
        for (int f = 0; f < 3; f++) begin
          clear_stim(); s_vl = vl; s_ff = ff; s_min = 1;
          s_fault = (f == 0) ? 0 : ((f == 1) ? 1 : 99);
          run();
        end

    // R6 R7: indexed and vertical-first requests
    for (int ff = 0; ff < 2; ff++)
      for (int ix = 0; ix < 2; ix++)
        for (int vf = 0; vf < 2; vf++)
          for (int f = 0; f < 2; f++) begin
            clear_stim(); s_vl = 5; s_ff = ff; s_idx = ix; s_vf = vf;
            s_fault = f ? 2 : 99;
            run();
          end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule